// File: doc/BRIEF.md
# ECC Field Status Scanner

After a page has been read through a hardware error-correcting engine, every ECC field of the page has a status entry, and four entries are packed into each 32-bit status word. This block walks those words once a scan is started. It fetches each word through a simple request/response read port and looks at its entries one at a time. For every correctable field it hands a job, made of the field index and the error count, to an external corrector. It waits for that job to be acknowledged before it moves to the next entry.

A status word of all zeros means that none of its four fields has an error, so the block skips it without decoding any entry. Inside a word that is not zero, every entry must report "correctable". The first entry that does not ends the scan at once as a failure. On a failure the block also sends a single-cycle request to reset the DMA path and the controller sequencer.

While the scan runs, the block keeps two figures: the largest error count seen in any one field, and the sum of all corrected counts. The page-level driver uses both when it decides what to do with the page.

Top module: `ecc_status_scanner`

## Requirements
- R1: A scan started with `steps` below 4 reads exactly one status word. Any other value reads floor(`steps`/4) words. Words are requested with `rd_idx` 0, 1, 2, … in ascending order.
- R2: `rd_req` stays high with an unchanged `rd_idx` until the cycle in which `rd_valid` is high. That cycle completes the read.
- R3: A status word equal to 0 produces no correction request. The scan moves straight on to the next word, or ends with success if it was the last word.
- R4: Entry i of word w sits in bits [8i+7:8i] and describes field 4w+i. Its bits [1:0] equal to 01 mean correctable, and its bits [6:2] give the error count. The entries of a nonzero word are examined in the order i = 0, 1, 2, 3.
- R5: Each correctable entry raises `fix_req` with `fix_field` and `fix_count`. These stay high and unchanged until `fix_done`. No further entry is examined before `fix_done`.
- R6: An entry of a nonzero word whose bits [1:0] are not 01 ends the scan. `done` and `fail` are both high, and no further read or correction request follows.
- R7: `abort_rst` is high for exactly one cycle, the cycle in which a failing scan raises `done`. It never goes high on a successful scan.
- R8: A scan that reaches the end of its last word raises `done` for one cycle with `fail` low. `max_flips` then equals the largest corrected count and `total_flips` the sum of all corrected counts. Both figures also cover the entries corrected before a failure.
- R9: `busy` goes high in the cycle after `start` is accepted and is low in the `done` cycle. A `start` that arrives while `busy` is high has no effect on the running scan.
- R10: After reset, `busy`, `done`, `fail`, `abort_rst`, `rd_req` and `fix_req` are low, and `max_flips` and `total_flips` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a scan when idle |
| steps | input | STEP_W | Number of ECC fields in the page |
| busy | output | 1 | Scan in progress |
| rd_req | output | 1 | Status word read request |
| rd_idx | output | STEP_W-2 | Index of the status word requested |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | 32 | Status word returned |
| fix_req | output | 1 | Correction job pending |
| fix_field | output | STEP_W | Field index of the job |
| fix_count | output | 5 | Error count of the job |
| fix_done | input | 1 | Corrector acknowledges the job |
| done | output | 1 | One-cycle end-of-scan strobe |
| fail | output | 1 | Last scan ended on an uncorrectable entry |
| abort_rst | output | 1 | One-cycle reset request for DMA path and sequencer |
| max_flips | output | 5 | Largest corrected count of the scan |
| total_flips | output | TOTAL_W | Sum of corrected counts of the scan |

## Verification
The hardest case to reach from the ports is a word that is nonzero but only partly valid. One example is a word whose first entry is a correctable field with count zero and whose other entries are zero: the scan must correct field 0 and then fail on field 1. Another is a failing entry placed after corrected entries in a later word. The bench builds these words on purpose. It also mixes randomly generated words, some all zero, some fully correctable and some with one bad lane at a random position, and serves them with random read and acknowledge latencies. A second `start` is fired in the middle of a scan to show that the scan is not disturbed.

// File: rtl/ecc_scan_pkg.sv
package ecc_scan_pkg;
   localparam int LANES    = 4;
   localparam int LANE_W   = 8;
   localparam int CNT_W    = 5;
   localparam int ENT_BITS = 2 + CNT_W;
   localparam logic [1:0] ST_CORRECTABLE = 2'b01;

   typedef enum logic [1:0] {
      SC_IDLE,
      SC_READ,
      SC_EXAM,
      SC_FIX
   } scan_state_e;

   typedef struct packed {
      logic             ok;
      logic [CNT_W-1:0] cnt;
   } entry_info_t;
endpackage

// File: rtl/ecc_word_seq.sv
module ecc_word_seq #(
   parameter int STEP_W = 8,
   localparam int WORD_W = STEP_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [STEP_W-1:0] steps,
   input  logic              advance,
   output logic [WORD_W-1:0] word_idx,
   output logic              last_word
);
   logic [WORD_W-1:0] limit_q;
   logic [WORD_W-1:0] idx_q;
   logic [WORD_W-1:0] limit_d;

   // fewer than one full status word still needs one read
   always_comb begin
      if (steps < STEP_W'(4)) limit_d = WORD_W'(1);
      else                    limit_d = steps[STEP_W-1:2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit_q <= WORD_W'(1);
         idx_q   <= '0;
      end else if (load) begin
         limit_q <= limit_d;
         idx_q   <= '0;
      end else if (advance) begin
         idx_q   <= idx_q + WORD_W'(1);
      end
   end

   assign word_idx  = idx_q;
   assign last_word = (idx_q == limit_q - WORD_W'(1));
endmodule

// File: rtl/ecc_entry_decode.sv
module ecc_entry_decode
   import ecc_scan_pkg::*;
#(
   parameter int N_LANES = LANES,
   localparam int SEL_W = $clog2(N_LANES)
) (
   input  logic [N_LANES*ENT_BITS-1:0] entries,
   input  logic [SEL_W-1:0]            sel,
   output entry_info_t                 info
);
   logic             lane_ok  [N_LANES];
   logic [CNT_W-1:0] lane_cnt [N_LANES];

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      assign lane_ok[g]  = (entries[g*ENT_BITS +: 2] == ST_CORRECTABLE);
      assign lane_cnt[g] = entries[g*ENT_BITS + 2 +: CNT_W];
   end

   always_comb begin
      info.ok  = lane_ok[sel];
      info.cnt = lane_cnt[sel];
   end
endmodule

// File: rtl/ecc_flip_stats.sv
module ecc_flip_stats
   import ecc_scan_pkg::*;
#(
   parameter int TOTAL_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               upd,
   input  logic [CNT_W-1:0]   cnt,
   output logic [CNT_W-1:0]   max_flips,
   output logic [TOTAL_W-1:0] total_flips
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_flips   <= '0;
         total_flips <= '0;
      end else if (clr) begin
         max_flips   <= '0;
         total_flips <= '0;
      end else if (upd) begin
         if (cnt > max_flips) max_flips <= cnt;
         total_flips <= total_flips + TOTAL_W'(cnt);
      end
   end
endmodule

// File: rtl/ecc_status_scanner.sv
module ecc_status_scanner
   import ecc_scan_pkg::*;
#(
   parameter int STEP_W  = 8,
   parameter int TOTAL_W = 16,
   localparam int WORD_W = STEP_W - 2,
   localparam int SEL_W  = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [STEP_W-1:0]  steps,
   output logic               busy,
   output logic               rd_req,
   output logic [WORD_W-1:0]  rd_idx,
   input  logic               rd_valid,
   input  logic [31:0]        rd_data,
   output logic               fix_req,
   output logic [STEP_W-1:0]  fix_field,
   output logic [CNT_W-1:0]   fix_count,
   input  logic               fix_done,
   output logic               done,
   output logic               fail,
   output logic               abort_rst,
   output logic [CNT_W-1:0]   max_flips,
   output logic [TOTAL_W-1:0] total_flips
);
   if (STEP_W < 3) begin : g_bad_step
      $error("STEP_W must be at least 3");
   end
   if (TOTAL_W < CNT_W + STEP_W) begin : g_bad_total
      $error("TOTAL_W too narrow for the worst-case sum");
   end
   if (LANES * LANE_W != 32) begin : g_bad_lanes
      $error("status word must hold exactly LANES entries");
   end

   scan_state_e               state_q;
   logic [LANES*ENT_BITS-1:0] ent_q;
   logic [SEL_W-1:0]          lane_q;
   logic [CNT_W-1:0]          cnt_q;
   logic                      done_q, fail_q, abort_q;
   logic                      seq_load, seq_adv, last_word;
   logic [WORD_W-1:0]         word_idx;
   logic                      rd_zero, lane_last;
   entry_info_t               info;
   logic [LANES*ENT_BITS-1:0] ent_d;

   // keep only the status and count bits of every lane
   for (genvar g = 0; g < LANES; g++) begin : g_pack
      assign ent_d[g*ENT_BITS +: ENT_BITS] = rd_data[g*LANE_W +: ENT_BITS];
   end

   assign rd_zero   = (rd_data == '0);
   assign lane_last = (lane_q == SEL_W'(LANES - 1));
   assign seq_load  = (state_q == SC_IDLE) && start;
   assign seq_adv   = ((state_q == SC_READ) && rd_valid && rd_zero && !last_word) ||
                      ((state_q == SC_FIX) && fix_done && lane_last && !last_word);

   ecc_word_seq #(.STEP_W(STEP_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (seq_load),
      .steps     (steps),
      .advance   (seq_adv),
      .word_idx  (word_idx),
      .last_word (last_word)
   );

   ecc_entry_decode #(.N_LANES(LANES)) u_dec (
      .entries (ent_q),
      .sel     (lane_q),
      .info    (info)
   );

   ecc_flip_stats #(.TOTAL_W(TOTAL_W)) u_stats (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (seq_load),
      .upd         ((state_q == SC_EXAM) && info.ok),
      .cnt         (info.cnt),
      .max_flips   (max_flips),
      .total_flips (total_flips)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SC_IDLE;
         ent_q   <= '0;
         lane_q  <= '0;
         cnt_q   <= '0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         abort_q <= 1'b0;
         unique case (state_q)
            SC_IDLE: begin
               if (start) begin
                  fail_q  <= 1'b0;
                  state_q <= SC_READ;
               end
            end
            SC_READ: begin
               if (rd_valid) begin
                  if (rd_zero) begin
                     if (last_word) begin
                        done_q  <= 1'b1;
                        state_q <= SC_IDLE;
                     end
                  end else begin
                     ent_q   <= ent_d;
                     lane_q  <= '0;
                     state_q <= SC_EXAM;
                  end
               end
            end
            SC_EXAM: begin
               if (info.ok) begin
                  cnt_q   <= info.cnt;
                  state_q <= SC_FIX;
               end else begin
                  done_q  <= 1'b1;
                  fail_q  <= 1'b1;
                  abort_q <= 1'b1;
                  state_q <= SC_IDLE;
               end
            end
            SC_FIX: begin
               if (fix_done) begin
                  if (!lane_last) begin
                     lane_q  <= lane_q + SEL_W'(1);
                     state_q <= SC_EXAM;
                  end else if (last_word) begin
                     done_q  <= 1'b1;
                     state_q <= SC_IDLE;
                  end else begin
                     state_q <= SC_READ;
                  end
               end
            end
            default: state_q <= SC_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != SC_IDLE);
   assign rd_req    = (state_q == SC_READ);
   assign rd_idx    = word_idx;
   assign fix_req   = (state_q == SC_FIX);
   assign fix_field = {word_idx, lane_q};
   assign fix_count = cnt_q;
   assign done      = done_q;
   assign fail      = fail_q;
   assign abort_rst = abort_q;
endmodule

// File: rtl/ecc_status_scanner_chk.sv
module ecc_status_scanner_chk #(
   parameter int STEP_W  = 8,
   parameter int TOTAL_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               rd_req,
   input logic [STEP_W-3:0]  rd_idx,
   input logic               rd_valid,
   input logic               fix_req,
   input logic [STEP_W-1:0]  fix_field,
   input logic [4:0]         fix_count,
   input logic               fix_done,
   input logic               done,
   input logic               fail,
   input logic               abort_rst,
   input logic [4:0]         max_flips,
   input logic [TOTAL_W-1:0] total_flips
);
   a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_valid |=> rd_req && $stable(rd_idx));

   a_r5_fix_hold: assert property (@(posedge clk) disable iff (!rst_n)
      fix_req && !fix_done |=> fix_req && $stable(fix_field) && $stable(fix_count));

   a_r7_abort_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
      abort_rst |-> done && fail);

   a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
      abort_rst |=> !abort_rst);

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r8_max_le_total: assert property (@(posedge clk) disable iff (!rst_n)
      TOTAL_W'(max_flips) <= total_flips);

   a_r8_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> total_flips >= $past(total_flips));

   a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req && !fix_req);
endmodule

bind ecc_status_scanner ecc_status_scanner_chk #(
   .STEP_W  (STEP_W),
   .TOTAL_W (TOTAL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .rd_req      (rd_req),
   .rd_idx      (rd_idx),
   .rd_valid    (rd_valid),
   .fix_req     (fix_req),
   .fix_field   (fix_field),
   .fix_count   (fix_count),
   .fix_done    (fix_done),
   .done        (done),
   .fail        (fail),
   .abort_rst   (abort_rst),
   .max_flips   (max_flips),
   .total_flips (total_flips)
);

// File: tb/tb_ecc_status_scanner.sv
module tb_ecc_status_scanner;
   localparam int STEP_W  = 8;
   localparam int TOTAL_W = 16;
   localparam int WORD_W  = STEP_W - 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [STEP_W-1:0]  steps = '0;
   logic               busy, rd_req, fix_req, done, fail, abort_rst;
   logic [WORD_W-1:0]  rd_idx;
   logic               rd_valid = 1'b0;
   logic [31:0]        rd_data = '0;
   logic [STEP_W-1:0]  fix_field;
   logic [4:0]         fix_count, max_flips;
   logic               fix_done = 1'b0;
   logic [TOTAL_W-1:0] total_flips;

   always #4 clk = ~clk;

   ecc_status_scanner #(.STEP_W(STEP_W), .TOTAL_W(TOTAL_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .steps(steps), .busy(busy),
      .rd_req(rd_req), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
      .fix_req(fix_req), .fix_field(fix_field), .fix_count(fix_count),
      .fix_done(fix_done), .done(done), .fail(fail), .abort_rst(abort_rst),
      .max_flips(max_flips), .total_flips(total_flips)
   );

   int n_chk = 0, n_fail = 0;
   logic [31:0] mem [0:63];
   int exp_field [0:255];
   int exp_cnt   [0:255];
   int exp_nfix, exp_nreads, exp_max, exp_tot;
   bit exp_fail;
   int got_nfix = 0, got_nreads = 0;
   int rd_lat_max = 2, fix_lat_max = 2;
   bit rd_pend = 0, fx_pend = 0;
   int rd_cur, rd_wait, fx_wait;
   int fx_field_cur;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // reference model built from R1, R3, R4, R6 and R8
   task automatic model(input int st);
      int nw;
      logic [7:0] b;
      nw = (st < 4) ? 1 : st / 4;
      exp_nfix = 0; exp_nreads = 0; exp_max = 0; exp_tot = 0; exp_fail = 0;
      for (int w = 0; w < nw && !exp_fail; w++) begin
         exp_nreads++;
         if (mem[w] != 0) begin
            for (int i = 0; i < 4 && !exp_fail; i++) begin
               b = mem[w][8*i +: 8];
               if (b[1:0] != 2'b01) exp_fail = 1;
               else begin
                  exp_field[exp_nfix] = w * 4 + i;
                  exp_cnt[exp_nfix]   = int'(b[6:2]);
                  exp_nfix++;
                  if (int'(b[6:2]) > exp_max) exp_max = int'(b[6:2]);
                  exp_tot += int'(b[6:2]);
               end
            end
         end
      end
   endtask

   function automatic logic [7:0] ok_byte(input int cnt);
      return {1'($urandom_range(0, 1)), 5'(cnt), 2'b01};
   endfunction

   function automatic logic [7:0] bad_byte();
      logic [1:0] s;
      s = 2'($urandom_range(0, 2));
      if (s == 2'b01) s = 2'b11;
      return {6'($urandom), s};
   endfunction

   function automatic logic [31:0] rand_word();
      int kind, bad;
      logic [31:0] w;
      kind = $urandom_range(0, 9);
      if (kind < 3) return 32'h0;
      for (int i = 0; i < 4; i++) w[8*i +: 8] = ok_byte($urandom_range(0, 31));
      if (kind >= 8) begin
         bad = $urandom_range(0, 3);
         w[8*bad +: 8] = bad_byte();
         for (int i = bad + 1; i < 4; i++) w[8*i +: 8] = 8'($urandom);
         if (w == 0) w = 32'h0000_0002;
      end
      return w;
   endfunction

   // read port responder: R1 order, R2 hold
   always @(negedge clk) begin
      if (!rst_n) begin
         rd_valid = 1'b0; rd_pend = 0;
      end else begin
         if (rd_valid) begin rd_valid = 1'b0; rd_pend = 0; end
         if (!rd_pend && rd_req) begin
            chk(int'(rd_idx) == got_nreads, "R1", "read index order", rd_idx, got_nreads);
            got_nreads++;
            rd_pend = 1; rd_cur = int'(rd_idx);
            rd_wait = $urandom_range(0, rd_lat_max);
         end
         if (rd_pend && !rd_valid) begin
            if (rd_wait == 0) begin
               chk(int'(rd_idx) == rd_cur && rd_req, "R2", "read index held", rd_idx, rd_cur);
               rd_valid = 1'b1; rd_data = mem[rd_cur];
            end else rd_wait--;
         end
      end
   end

   // corrector responder: R4 field/count, R5 hold
   always @(negedge clk) begin
      if (!rst_n) begin
         fix_done = 1'b0; fx_pend = 0;
      end else begin
         if (fix_done) begin fix_done = 1'b0; fx_pend = 0; end
         if (!fx_pend && fix_req) begin
            if (got_nfix < exp_nfix) begin
               chk(int'(fix_field) == exp_field[got_nfix], "R4", "fix field",
                   fix_field, exp_field[got_nfix]);
               chk(int'(fix_count) == exp_cnt[got_nfix], "R4", "fix count",
                   fix_count, exp_cnt[got_nfix]);
            end else chk(0, "R6", "unexpected fix request", got_nfix, exp_nfix);
            got_nfix++;
            fx_pend = 1; fx_field_cur = int'(fix_field);
            fx_wait = $urandom_range(0, fix_lat_max);
         end
         if (fx_pend && !fix_done) begin
            if (fx_wait == 0) begin
               chk(fix_req && int'(fix_field) == fx_field_cur, "R5", "fix held",
                   fix_field, fx_field_cur);
               fix_done = 1'b1;
            end else fx_wait--;
         end
      end
   end

   task automatic run_scan(input int st, input bit poke);
      model(st);
      got_nfix = 0; got_nreads = 0;
      @(negedge clk); start = 1'b1; steps = STEP_W'(st);
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R9", "busy after start", busy, 1);
      if (poke) begin
         start = 1'b1; steps = STEP_W'(255);
         @(negedge clk); start = 1'b0;
      end
      forever begin
         if (done) break;
         @(negedge clk);
      end
      chk(fail == exp_fail, exp_fail ? "R6" : "R8", "fail flag", fail, exp_fail);
      chk(abort_rst == exp_fail, "R7", "abort with done", abort_rst, exp_fail);
      chk(busy == 1'b0, "R9", "idle at done", busy, 0);
      chk(int'(max_flips) == exp_max, "R8", "max flips", max_flips, exp_max);
      chk(int'(total_flips) == exp_tot, "R8", "total flips", total_flips, exp_tot);
      chk(got_nfix == exp_nfix, "R3", "fix request count", got_nfix, exp_nfix);
      chk(got_nreads == exp_nreads, "R1", "word read count", got_nreads, exp_nreads);
      @(negedge clk);
      chk(done == 1'b0 && abort_rst == 1'b0, "R7", "single-cycle strobes",
          {done, abort_rst}, 0);
   endtask

   bit finished = 0;

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 64; i++) mem[i] = 32'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk({busy, done, fail, abort_rst, rd_req, fix_req} == 6'b0, "R10", "control outputs",
          {busy, done, fail, abort_rst, rd_req, fix_req}, 0);
      chk(max_flips == 0 && total_flips == 0, "R10", "statistics", total_flips, 0);

      // R1/R3: steps 0 reads one zero word
      run_scan(0, 0);
      // R4/R8: all lanes correctable
      mem[0] = {ok_byte(0), ok_byte(31), ok_byte(17), ok_byte(5)};
      run_scan(3, 0);
      // R6: count-zero correctable lane followed by empty lanes
      mem[0] = 32'h0000_0001;
      run_scan(4, 0);
      // R6/R7: failure in second word after corrections
      mem[0] = {ok_byte(9), ok_byte(2), ok_byte(30), ok_byte(1)};
      mem[1] = {ok_byte(4), ok_byte(4), 8'h02, ok_byte(3)};
      mem[2] = {4{ok_byte(7)}};
      run_scan(12, 0);
      // R1: floor division, word 1 must not be read
      mem[0] = 32'h0;
      mem[1] = 32'hFFFF_FFFF;
      run_scan(7, 0);
      // R3: zero word between good words
      mem[0] = {4{ok_byte(6)}};
      mem[1] = 32'h0;
      mem[2] = {ok_byte(12), ok_byte(0), ok_byte(19), ok_byte(8)};
      run_scan(12, 0);
      // R9: start during a scan is ignored
      rd_lat_max = 4; fix_lat_max = 4;
      run_scan(12, 1);

      // constrained random scans
      for (int n = 0; n < 40; n++) begin
         for (int i = 0; i < 64; i++) mem[i] = rand_word();
         rd_lat_max  = $urandom_range(0, 3);
         fix_lat_max = $urandom_range(0, 3);
         run_scan((n % 10 == 9) ? $urandom_range(0, 255) : $urandom_range(0, 40), n % 7 == 3);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL ALL watchdog expired: actual=%0d expected=%0d", 200000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule